// File: doc/BRIEF.md
# Accumulator 8-bit Processor Core

This block is a small multi-cycle processor with one accumulator. All of its registers sit on a single 8-bit internal bus: the program counter, the memory address register, the instruction register, the accumulator, the operand register and the output register. An adder/subtractor and a zero flag complete the datapath. Program and data share one 256-byte memory. Its contents are set at elaboration by a function, which builds one of several built-in programs chosen by a parameter.

A controller steps through fixed phases. It fetches the opcode, decodes it and fetches an operand byte when the instruction has one. It then runs a memory phase and an arithmetic phase when the instruction needs them. All state changes on the falling clock edge. Every control strobe is active high. A run enable freezes the whole core when it is low. An undefined opcode parks the core in a halted state. The core leaves that state only on reset. The output register drives an 8-bit port, and the current bus value is brought out for debug.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous active-low reset clears the program counter, accumulator, operand, address and instruction registers, the output register and the zero flag. After reset `halted` is 0, `out_port` is 0x00, and the first fetch puts address 0x00 on `bus_view`.
- R2: While `run_en` is low, no register, memory byte or controller state changes, so `out_port`, `halted` and `bus_view` hold their values.
- R3: LDI (0x05, immediate in the second byte) loads the accumulator. OUT (0x07, one byte) copies the accumulator into `out_port`. In a program that starts with LDI then OUT, `out_port` changes on the 8th falling edge after `run_en` rises.
- R4: LDA (0x01), ADD (0x02) and SUB (0x03) take an address byte. They load, add or subtract the memory byte at that address, and the result wraps modulo 256. ADD and SUB set the zero flag from their result.
- R5: STA (0x04, address byte) writes the accumulator to memory, and a later LDA of that address returns the value.
- R6: CMP (0x08, address byte) sets the zero flag when the accumulator equals the memory byte, and leaves the accumulator unchanged.
- R7: JZ (0x09, address byte) loads the program counter with the address only when the zero flag is 1. Otherwise it continues at the next instruction. LDI, LDA, STA, JMP, OUT and NOP leave the flag unchanged.
- R8: JMP (0x06, address byte) always loads the program counter with the address.
- R9: The program counter wraps from 0xFF to 0x00. This applies during opcode fetch and during operand fetch.
- R10: Any opcode from 0x0A to 0xFF sets `halted`. The core then stays halted, and `out_port` stays frozen, until reset.
- R11: NOP (0x00) and OUT take 3 cycles. LDI, JMP and JZ take 5 cycles. LDA and STA take 6 cycles. ADD, SUB and CMP take 7 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its falling edge |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | High lets the core advance; low freezes it |
| out_port | output | 8 | Output register value |
| halted | output | 1 | High after an undefined opcode, until reset |
| bus_view | output | 8 | Current value on the internal bus |

## Verification
The core advances on falling edges, and the bench drives and samples on rising edges, so each sample falls half a cycle after the edge that produced it. The first OUT result comes 8 falling edges after `run_en` rises. The bench counts those edges and checks that the port is still 0x00 after 7 edges and carries the value after 8. Later results depend on per-instruction cycle counts of 3, 5, 6 and 7. For those, a monitor logs every change of `out_port` at rising edges, and the logged sequence is compared with a table once each program has halted. A wrong jump or a wrong flag therefore appears as a missing, extra or wrong entry, whenever it happens.

// File: rtl/acc_cpu_pkg.sv
// Shared constants, opcode values, controller states, control word and
// built-in program images for the accumulator core.
// Assumes an 8-bit data path and an 8-bit address (256-byte memory).
package acc_cpu_pkg;
    localparam int DW = 8;
    localparam int AW = 8;

    localparam logic [DW-1:0] OP_NOP = 8'h00;
    localparam logic [DW-1:0] OP_LDA = 8'h01;
    localparam logic [DW-1:0] OP_ADD = 8'h02;
    localparam logic [DW-1:0] OP_SUB = 8'h03;
    localparam logic [DW-1:0] OP_STA = 8'h04;
    localparam logic [DW-1:0] OP_LDI = 8'h05;
    localparam logic [DW-1:0] OP_JMP = 8'h06;
    localparam logic [DW-1:0] OP_OUT = 8'h07;
    localparam logic [DW-1:0] OP_CMP = 8'h08;
    localparam logic [DW-1:0] OP_JZ  = 8'h09;
    localparam logic [DW-1:0] OP_LAST = OP_JZ;

    typedef enum logic [2:0] {
        ST_FADDR, ST_FDATA, ST_DEC, ST_OADDR, ST_ODATA, ST_MEM, ST_ALU, ST_HALT
    } phase_t;

    // Bus source selects (one at most) and gated load strobes.
    typedef struct packed {
        logic src_pc;
        logic src_mem;
        logic src_acc;
        logic src_alu;
        logic ld_mar;
        logic ld_ir;
        logic ld_acc;
        logic ld_opd;
        logic ld_out;
        logic ld_pc;
        logic pc_step;
        logic mem_wr;
        logic flag_wr;
        logic alu_sub;
    } ctl_t;

    // Initial memory byte for program image `prog` at address `a`.
    function automatic logic [DW-1:0] image_byte(input int prog, input logic [AW-1:0] a);
        logic [DW-1:0] v;
        v = 8'h00;
        if (prog == 0) begin
            case (a)
                8'h00: v = OP_LDI;  8'h01: v = 8'h5A;
                8'h02: v = OP_OUT;
                8'h03: v = OP_LDA;  8'h04: v = 8'h40;
                8'h05: v = OP_ADD;  8'h06: v = 8'h41;
                8'h07: v = OP_OUT;
                8'h08: v = OP_SUB;  8'h09: v = 8'h42;
                8'h0A: v = OP_STA;  8'h0B: v = 8'h43;
                8'h0C: v = OP_LDI;  8'h0D: v = 8'h00;
                8'h0E: v = OP_LDA;  8'h0F: v = 8'h43;
                8'h10: v = OP_OUT;
                8'h11: v = OP_NOP;
                8'h12: v = 8'hFF;
                8'h40: v = 8'hF0;   8'h41: v = 8'h20;  8'h42: v = 8'h15;
                default: v = 8'h00;
            endcase
        end else if (prog == 1) begin
            case (a)
                8'h00: v = OP_LDI;  8'h01: v = 8'h07;
                8'h02: v = OP_CMP;  8'h03: v = 8'h40;
                8'h04: v = OP_JZ;   8'h05: v = 8'h08;
                8'h06: v = OP_OUT;
                8'h07: v = 8'hFF;
                8'h08: v = OP_OUT;
                8'h09: v = OP_CMP;  8'h0A: v = 8'h41;
                8'h0B: v = OP_JZ;   8'h0C: v = 8'h07;
                8'h0D: v = OP_SUB;  8'h0E: v = 8'h41;
                8'h0F: v = OP_OUT;
                8'h10: v = OP_SUB;  8'h11: v = 8'h42;
                8'h12: v = OP_LDI;  8'h13: v = 8'h09;
                8'h14: v = OP_JZ;   8'h15: v = 8'h18;
                8'h16: v = OP_OUT;
                8'h17: v = 8'hFF;
                8'h18: v = OP_OUT;
                8'h19: v = OP_JMP;  8'h1A: v = 8'h1D;
                8'h1B: v = OP_LDI;  8'h1C: v = 8'h33;
                8'h1D: v = OP_OUT;
                8'h1E: v = 8'h0A;
                8'h40: v = 8'h07;   8'h41: v = 8'h03;  8'h42: v = 8'h04;
                default: v = 8'h00;
            endcase
        end else begin
            case (a)
                8'h00: v = OP_JZ;   8'h01: v = 8'h10;
                8'h02: v = OP_CMP;  8'h03: v = 8'h50;
                8'h04: v = OP_JMP;  8'h05: v = 8'hFC;
                8'h10: v = OP_LDI;  8'h11: v = 8'h3C;
                8'h12: v = OP_OUT;
                8'h13: v = 8'hFF;
                8'hFC: v = OP_LDI;  8'hFD: v = 8'hC3;
                8'hFE: v = OP_OUT;
                8'hFF: v = OP_NOP;
                default: v = 8'h00;
            endcase
        end
        return v;
    endfunction
endpackage

// File: rtl/acc_cpu_mem.sv
// Shared program/data memory: asynchronous read, write on the falling edge.
// Assumes the address comes from the address register and the write data
// from the bus; contents start from the program image chosen by PROG.
module acc_cpu_mem
    import acc_cpu_pkg::*;
#(
    parameter int PROG  = 0,
    parameter int WIDTH = DW,
    parameter int ABITS = AW
) (
    input  logic             clk,
    input  logic             we,
    input  logic [ABITS-1:0] addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    localparam int DEPTH = 1 << ABITS;

    logic [WIDTH-1:0] cells [DEPTH];

    // Load the program image at start-up.
    initial begin
        for (int i = 0; i < DEPTH; i++) cells[i] = image_byte(PROG, ABITS'(i));
    end

    // Store the bus value when the controller writes.
    always_ff @(negedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/acc_cpu_alu.sv
// Adder/subtractor on the accumulator and operand register, result modulo
// 2**WIDTH, plus a zero indication of the result. Purely combinational.
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int WIDTH = DW
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] res,
    output logic             zero
);
    // Add or subtract, dropping the carry out.
    always_comb begin
        res  = sub ? (a - b) : (a + b);
        zero = (res == '0);
    end
endmodule

// File: rtl/acc_cpu_ctrl.sv
// Phase sequencer: drives bus source selects and load strobes from the
// current phase, the instruction register and the zero flag.
// Assumes the instruction register is valid from the decode phase onward.
// Load strobes are gated by run_en; source selects are not.
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [DW-1:0] ir,
    input  logic          zflag,
    output ctl_t          ctl,
    output logic          halted
);
    phase_t phase, phase_nx;
    ctl_t   raw;

    // Choose selects, strobes and next phase for the current phase.
    always_comb begin
        raw      = '0;
        phase_nx = phase;
        case (phase)
            ST_FADDR: begin raw.src_pc = 1'b1; raw.ld_mar = 1'b1; phase_nx = ST_FDATA; end
            ST_FDATA: begin
                raw.src_mem = 1'b1; raw.ld_ir = 1'b1; raw.pc_step = 1'b1;
                phase_nx = ST_DEC;
            end
            ST_DEC: begin
                if (ir == OP_NOP) phase_nx = ST_FADDR;
                else if (ir == OP_OUT) begin
                    raw.src_acc = 1'b1; raw.ld_out = 1'b1; phase_nx = ST_FADDR;
                end else if (ir > OP_LAST) phase_nx = ST_HALT;
                else phase_nx = ST_OADDR;
            end
            ST_OADDR: begin raw.src_pc = 1'b1; raw.ld_mar = 1'b1; phase_nx = ST_ODATA; end
            ST_ODATA: begin
                raw.src_mem = 1'b1;
                phase_nx    = ST_FADDR;
                if (ir == OP_JMP || (ir == OP_JZ && zflag)) raw.ld_pc = 1'b1;
                else raw.pc_step = 1'b1;
                if (ir == OP_LDI) raw.ld_acc = 1'b1;
                if (ir == OP_LDA || ir == OP_STA || ir == OP_ADD ||
                    ir == OP_SUB || ir == OP_CMP) begin
                    raw.ld_mar = 1'b1; phase_nx = ST_MEM;
                end
            end
            ST_MEM: begin
                phase_nx = ST_FADDR;
                if (ir == OP_STA) begin
                    raw.src_acc = 1'b1; raw.mem_wr = 1'b1;
                end else if (ir == OP_LDA) begin
                    raw.src_mem = 1'b1; raw.ld_acc = 1'b1;
                end else begin
                    raw.src_mem = 1'b1; raw.ld_opd = 1'b1; phase_nx = ST_ALU;
                end
            end
            ST_ALU: begin
                raw.src_alu = 1'b1; raw.flag_wr = 1'b1;
                raw.alu_sub = (ir != OP_ADD);
                raw.ld_acc  = (ir != OP_CMP);
                phase_nx    = ST_FADDR;
            end
            default: phase_nx = ST_HALT;
        endcase
    end

    // Gate every state-changing strobe with run_en.
    always_comb begin
        ctl = raw;
        if (!run_en) begin
            ctl.ld_mar = 1'b0; ctl.ld_ir = 1'b0; ctl.ld_acc = 1'b0;
            ctl.ld_opd = 1'b0; ctl.ld_out = 1'b0; ctl.ld_pc = 1'b0;
            ctl.pc_step = 1'b0; ctl.mem_wr = 1'b0; ctl.flag_wr = 1'b0;
        end
    end

    // Advance the phase on the falling edge while running.
    always_ff @(negedge clk) begin
        if (!rst_n) phase <= ST_FADDR;
        else if (run_en) phase <= phase_nx;
    end

    assign halted = (phase == ST_HALT);

    // R10
    halt_sticky_chk: assert property (@(negedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R2
    freeze_phase_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !run_en |=> $stable(phase));

    // R11
    nop_len_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (run_en && phase == ST_DEC && ir == OP_NOP) |=> (phase == ST_FADDR));

    // R11
    alu_after_mem_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (run_en && phase == ST_MEM && (ir == OP_ADD || ir == OP_SUB || ir == OP_CMP))
        |=> (phase == ST_ALU));
endmodule

// File: rtl/acc_cpu.sv
// Accumulator processor top: bus multiplexer, datapath registers, memory,
// adder/subtractor and sequencer. All registers load from the shared bus on
// the falling clock edge; reset is synchronous and active low.
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int PROG = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    output logic [DW-1:0] out_port,
    output logic          halted,
    output logic [DW-1:0] bus_view
);
    logic [AW-1:0] pc, mar;
    logic [DW-1:0] ir, acc, opd, outr, bus, mem_q, alu_q;
    logic          zflag, alu_zero;
    ctl_t          ctl;

    acc_cpu_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .ir(ir),
        .zflag(zflag), .ctl(ctl), .halted(halted)
    );

    acc_cpu_mem #(.PROG(PROG)) u_mem (
        .clk(clk), .we(ctl.mem_wr), .addr(mar), .wdata(bus), .rdata(mem_q)
    );

    acc_cpu_alu u_alu (
        .a(acc), .b(opd), .sub(ctl.alu_sub), .res(alu_q), .zero(alu_zero)
    );

    // Drive the shared bus from the one selected source.
    always_comb begin
        bus = '0;
        if (ctl.src_pc)       bus = pc;
        else if (ctl.src_mem) bus = mem_q;
        else if (ctl.src_acc) bus = acc;
        else if (ctl.src_alu) bus = alu_q;
    end

    // Load each datapath register from the bus when strobed.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            pc <= '0; mar <= '0; ir <= '0; acc <= '0;
            opd <= '0; outr <= '0; zflag <= 1'b0;
        end else begin
            if (ctl.ld_pc)        pc <= bus;
            else if (ctl.pc_step) pc <= pc + 1'b1;
            if (ctl.ld_mar)  mar  <= bus;
            if (ctl.ld_ir)   ir   <= bus;
            if (ctl.ld_acc)  acc  <= bus;
            if (ctl.ld_opd)  opd  <= bus;
            if (ctl.ld_out)  outr <= bus;
            if (ctl.flag_wr) zflag <= alu_zero;
        end
    end

    assign out_port = outr;
    assign bus_view = bus;

    // R1
    reset_clear_chk: assert property (@(negedge clk)
        !rst_n |=> (pc == '0 && acc == '0 && outr == '0 && !zflag));

    // R6
    cmp_keeps_acc_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (ctl.flag_wr && !ctl.ld_acc) |=> $stable(acc));

    // R9
    pc_wrap_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (ctl.pc_step && pc == 8'hFF) |=> (pc == 8'h00));

    // R2
    freeze_out_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !run_en |=> ($stable(outr) && $stable(pc) && $stable(acc)));
endmodule

// File: tb/acc_cpu_test.sv
// Bench: three cores with different program images, a log of out_port
// changes per core compared against a table, then directed checks.
module acc_cpu_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic [7:0] out0, out1, out2, bus0, bus1, bus2;
    logic h0, h1, h2;
    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    acc_cpu #(.PROG(0)) uut (.clk(clk), .rst_n(rst_n), .run_en(run_en),
        .out_port(out0), .halted(h0), .bus_view(bus0));
    acc_cpu #(.PROG(1)) uut_flag (.clk(clk), .rst_n(rst_n), .run_en(run_en),
        .out_port(out1), .halted(h1), .bus_view(bus1));
    acc_cpu #(.PROG(2)) uut_wrap (.clk(clk), .rst_n(rst_n), .run_en(run_en),
        .out_port(out2), .halted(h2), .bus_view(bus2));

    // Expected out_port sequences: {core[3:0], index[3:0], value[7:0]}.
    localparam int NEXP = 8;
    localparam logic [15:0] EXP [NEXP] = '{
        16'h005A, 16'h0110, 16'h02FB,
        16'h1007, 16'h1104, 16'h1209,
        16'h20C3, 16'h213C
    };
    localparam string EXP_REQ [NEXP] = '{
        "R3", "R4", "R5", "R6", "R7", "R7", "R9", "R9"
    };

    logic [7:0] log_v [3][8];
    int         log_n [3];
    logic [7:0] prev [3];

    // Log every change of each output port while out of reset.
    always @(posedge clk) begin
        if (rst_n) begin
            if (out0 != prev[0] && log_n[0] < 8) begin log_v[0][log_n[0]] <= out0; log_n[0] <= log_n[0] + 1; end
            if (out1 != prev[1] && log_n[1] < 8) begin log_v[1][log_n[1]] <= out1; log_n[1] <= log_n[1] + 1; end
            if (out2 != prev[2] && log_n[2] < 8) begin log_v[2][log_n[2]] <= out2; log_n[2] <= log_n[2] + 1; end
        end
        prev[0] <= out0; prev[1] <= out1; prev[2] <= out2;
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] snap_bus, snap_out;
        log_n = '{0, 0, 0};
        prev  = '{8'h00, 8'h00, 8'h00};
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        // R1: reset state
        check("R1", out0, 8'h00);
        check("R1", {7'd0, h0}, 8'h00);
        check("R1", bus0, 8'h00);
        // R2: held idle with run_en low
        repeat (10) @(posedge clk);
        check("R2", bus0, 8'h00);
        check("R2", out0, 8'h00);
        // R3: first OUT lands on the 8th falling edge
        run_en = 1'b1;
        repeat (7) @(posedge clk);
        check("R3", out0, 8'h00);
        @(posedge clk);
        check("R3", out0, 8'h5A);
        // R2: pause mid-program
        repeat (10) @(posedge clk);
        run_en = 1'b0;
        @(posedge clk);
        snap_bus = bus0; snap_out = out0;
        repeat (15) @(posedge clk);
        check("R2", bus0, snap_bus);
        check("R2", out0, snap_out);
        check("R2", {7'd0, h0}, 8'h00);
        run_en = 1'b1;
        while (!(h0 && h1 && h2)) @(posedge clk);
        repeat (2) @(posedge clk);
        // Table walk over the logged output sequences
        for (int i = 0; i < NEXP; i++) begin
            check(EXP_REQ[i], log_v[EXP[i][15:12]][EXP[i][11:8]], EXP[i][7:0]);
        end
        // R8: the JMP skipped the LDI 0x33, so only three outputs appear
        check("R8", 8'(log_n[1]), 8'd3);
        check("R5", 8'(log_n[0]), 8'd3);
        // R10: halted stays set and the port stays frozen
        snap_out = out1;
        repeat (20) @(posedge clk);
        check("R10", {7'd0, h1}, 8'h01);
        check("R10", out1, snap_out);
        check("R10", {7'd0, h0 & h2}, 8'h01);
        // R1: reset during a halt clears the state
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        check("R1", out0, 8'h00);
        check("R1", {7'd0, h0}, 8'h00);
        rst_n = 1'b1;
        log_n = '{0, 0, 0};
        @(posedge clk);
        while (!h0) @(posedge clk);
        repeat (2) @(posedge clk);
        check("R1", log_v[0][0], 8'h5A);
        check("R5", log_v[0][2], 8'hFB);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule